// File: doc/BRIEF.md
# Programmable clock-enable divider bank with update handshake

The block holds a small bank of integer dividers that share one 32-bit control word. Each divider produces a one-cycle clock-enable pulse every N input cycles, where N is its field value plus one. Software changes a ratio by writing the control word. In that write, each field carries its own write-enable bit, placed sixteen bits above the field's lowest bit, so one write can retune one divider without disturbing the others.

A new ratio is never applied in the middle of an output period. An accepted write latches the value and raises that divider's busy bit in a shared status word. The latched value becomes active at the next pulse boundary, and the busy bit then drops. Software waits for the busy bit to read 0, writes, and then waits for it to read 0 again. Fields sit at bit `i*FIELD_W`. The whole field area must fit in the lower sixteen bits, and a parameter set that breaks this rule stops elaboration. The busy bit of divider i sits at status bit `MON_BASE+i`.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every field reads back as RST_DIV (default 3), every busy bit reads 0, and the first pulse of each divider comes RST_DIV+1 cycles after the internal reset is released.
- R2: Output `clk_en[i]` is high for exactly one cycle out of every F+1 cycles, where F is the active ratio of divider i.
- R3: A write to CTRL_ADDR updates field i (bits `[i*FIELD_W +: FIELD_W]`) only when bit `i*FIELD_W+16` of the written word is 1. Otherwise the field keeps its value. A read of CTRL_ADDR returns the latched fields, with every other bit 0.
- R4: A write to any address other than CTRL_ADDR changes no field, busy bit or output. A read of any address other than CTRL_ADDR or STAT_ADDR returns 0.
- R5: A read of STAT_ADDR returns divider i's busy flag at bit MON_BASE+i (default 2), with every other bit 0. The flag is 1 from the cycle after an accepted write until the cycle after the boundary pulse that applies the value.
- R6: A latched ratio becomes active only at a pulse boundary, so the period in progress completes at the old ratio and the next period uses the new one.
- R7: A write while busy is set replaces the latched value, so only the last value written before the boundary is applied.
- R8: A write accepted in the very cycle of a boundary pulse applies the previously latched value at that boundary. The new value stays pending and the busy flag stays 1 until the following boundary.
- R9: A field value of 0 gives a pulse on every cycle, and an all-ones field gives one pulse every 2^FIELD_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for the read and the write |
| reg_wdata | input | 32 | Write data: fields in the low half, write enables in the high half |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| clk_en | output | NUM_DIV | One-cycle divided clock-enable pulse per divider |

## Verification
Two events can fall in the same cycle for one divider: a control write and the boundary pulse that applies an earlier latched value. The bench steps a reference model until a divider is due to pulse while busy, and writes a new value in exactly that cycle. The check passes only if the old value sets the next period, the busy bit stays 1, and the new value governs the period after that. Random writes with random enable bits produce further collisions, and every cycle's pulses and status reads are compared against the model.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FLD_TOP = 16;

  function automatic int unsigned fld_shift(input int unsigned idx,
                                            input int unsigned fw);
    return idx * fw;
  endfunction

  function automatic int unsigned wen_bit(input int unsigned idx,
                                          input int unsigned fw);
    return idx * fw + FLD_TOP;
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/clkdiv_field_reg.sv
module clkdiv_field_reg #(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned RST_DIV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [FIELD_W-1:0] wr_val,
  input  logic               apply,
  output logic [FIELD_W-1:0] fld_q,
  output logic               busy_q
);
  logic [FIELD_W-1:0] fld_d;
  logic               busy_d;
  logic               fld_en;

  assign fld_en = wr_hit;

  always_comb begin
    fld_d  = fld_q;
    busy_d = busy_q;
    if (fld_en) begin
      fld_d = wr_val;
    end
    if (wr_hit) begin
      busy_d = 1'b1;
    end else if (apply) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= FIELD_W'(RST_DIV);
    end else if (fld_en) begin
      fld_q <= fld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> busy_q); // R5
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !wr_hit) |=> !busy_q); // R5
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(fld_q)); // R3
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned RST_DIV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] load_val,
  output logic [FIELD_W-1:0] cur_o,
  output logic               tick_o
);
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] cnt_d;
  logic [FIELD_W-1:0] cur_q;
  logic [FIELD_W-1:0] cur_d;
  logic               tick;

  assign tick = (cnt_q == cur_q);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + FIELD_W'(1);
    cur_d = load ? load_val : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= FIELD_W'(RST_DIV);
    end else if (load) begin
      cur_q <= cur_d;
    end
  end

  assign cur_o  = cur_q;
  assign tick_o = tick;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cur_q); // R2
  AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_q != '0 && !load) |=> !tick); // R2
endmodule

// File: rtl/clkdiv_readmux.sv
module clkdiv_readmux
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_DIV   = 3,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned MON_BASE  = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h240,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h700
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_DIV*FIELD_W-1:0] fld_flat,
  input  logic [NUM_DIV-1:0]         busy,
  output logic [REG_W-1:0]           rdata
);
  logic [REG_W-1:0] ctrl_word;
  logic [REG_W-1:0] stat_word;

  always_comb begin
    ctrl_word = '0;
    stat_word = '0;
    for (int unsigned i = 0; i < NUM_DIV; i++) begin
      ctrl_word[fld_shift(i, FIELD_W) +: FIELD_W] = fld_flat[i*FIELD_W +: FIELD_W];
      stat_word[MON_BASE + i] = busy[i];
    end
  end

  always_comb begin
    if (addr == CTRL_ADDR) begin
      rdata = ctrl_word;
    end else if (addr == STAT_ADDR) begin
      rdata = stat_word;
    end else begin
      rdata = '0;
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_DIV   = 3,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned MON_BASE  = 2,
  parameter int unsigned RST_DIV   = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h240,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_DIV-1:0] clk_en
);
  localparam int unsigned FLD_BITS = NUM_DIV * FIELD_W;

  if (FLD_BITS > FLD_TOP) begin : g_cfg_bad_fields
    $error("divider fields exceed the lower sixteen bits");
  end
  if (MON_BASE + NUM_DIV > REG_W) begin : g_cfg_bad_mon
    $error("busy bits exceed the status word");
  end

  logic                rst_n_int;
  logic                ctrl_sel;
  logic [NUM_DIV-1:0]  wr_hit;
  logic [NUM_DIV-1:0]  busy;
  logic [NUM_DIV-1:0]  tick;
  logic [NUM_DIV-1:0]  apply;
  logic [FLD_BITS-1:0] fld_flat;
  logic [FLD_BITS-1:0] cur_flat;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata;

  clkdiv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign ctrl_sel = reg_wr && (reg_addr == CTRL_ADDR);

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    localparam int unsigned SH = fld_shift(i, FIELD_W);
    localparam int unsigned WE = wen_bit(i, FIELD_W);

    assign wr_hit[i] = ctrl_sel && reg_wdata[WE];
    assign apply[i]  = busy[i] && tick[i];

    clkdiv_field_reg #(
      .FIELD_W (FIELD_W),
      .RST_DIV (RST_DIV)
    ) u_fld (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .wr_hit (wr_hit[i]),
      .wr_val (reg_wdata[SH +: FIELD_W]),
      .apply  (apply[i]),
      .fld_q  (fld_flat[i*FIELD_W +: FIELD_W]),
      .busy_q (busy[i])
    );

    clkdiv_counter #(
      .FIELD_W (FIELD_W),
      .RST_DIV (RST_DIV)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .load     (apply[i]),
      .load_val (fld_flat[i*FIELD_W +: FIELD_W]),
      .cur_o    (cur_flat[i*FIELD_W +: FIELD_W]),
      .tick_o   (tick[i])
    );

    AST_RATIO_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n_int)
      !tick[i] |=> $stable(cur_flat[i*FIELD_W +: FIELD_W])); // R6
    AST_APPLY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n_int)
      (busy[i] && tick[i]) |=> (cur_flat[i*FIELD_W +: FIELD_W] ==
                                $past(fld_flat[i*FIELD_W +: FIELD_W]))); // R8
    AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n_int)
      (!busy[i] && !wr_hit[i]) |=> (cur_flat[i*FIELD_W +: FIELD_W] ==
                                   fld_flat[i*FIELD_W +: FIELD_W])); // R7
  end

  assign clk_en = tick;

  clkdiv_readmux #(
    .NUM_DIV   (NUM_DIV),
    .FIELD_W   (FIELD_W),
    .MON_BASE  (MON_BASE),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_rd (
    .addr     (reg_addr),
    .fld_flat (fld_flat),
    .busy     (busy),
    .rdata    (reg_rdata)
  );
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NUM   = 3;
  localparam int FW    = 4;
  localparam int MON   = 2;
  localparam int RDIV  = 3;
  localparam logic [11:0] CTRL = 12'h240;
  localparam logic [11:0] STAT = 12'h700;
  localparam logic [11:0] OTHR = 12'h244;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [NUM-1:0] clk_en;

  int checks;
  int errors;
  int cyc;
  int m_cnt [NUM];
  int m_cur [NUM];
  int m_fld [NUM];
  int m_busy[NUM];

  clkdiv_bank #(
    .NUM_DIV (NUM), .FIELD_W (FW), .MON_BASE (MON), .RST_DIV (RDIV),
    .ADDR_W (12), .CTRL_ADDR (CTRL), .STAT_ADDR (STAT)
  ) dut (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .clk_en (clk_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < NUM; i++) begin
      if (a == CTRL) v = v | (32'(m_fld[i]) << (i*FW));
      if (a == STAT) v = v | (32'(m_busy[i]) << (MON+i));
    end
    return v;
  endfunction

  function automatic logic [NUM-1:0] exp_en();
    logic [NUM-1:0] v;
    for (int i = 0; i < NUM; i++) v[i] = (m_cnt[i] == m_cur[i]);
    return v;
  endfunction

  task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input string tag);
    logic [31:0] er;
    logic [NUM-1:0] ee;
    string rtag;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    ee = exp_en();
    er = exp_rd(a);
    chk(clk_en == ee, tag, 32'(clk_en), 32'(ee));
    rtag = (a == STAT) ? "R5" : ((a == CTRL) ? "R3" : "R4");
    chk(reg_rdata == er, rtag, reg_rdata, er);
    for (int i = 0; i < NUM; i++) begin
      int tk, hit, ap;
      tk  = (m_cnt[i] == m_cur[i]) ? 1 : 0;
      hit = (wr && a == CTRL && d[i*FW+16]) ? 1 : 0;
      ap  = (m_busy[i] != 0 && tk != 0) ? 1 : 0;
      m_cnt[i] = tk ? 0 : m_cnt[i] + 1;
      if (ap) m_cur[i] = m_fld[i];
      if (hit) m_fld[i] = int'((d >> (i*FW)) & ((1 << FW) - 1));
      if (hit) m_busy[i] = 1;
      else if (ap) m_busy[i] = 0;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, STAT, 32'h0, tag);
  endtask

  task automatic wait_clear(input int i, input string tag);
    while (m_busy[i] != 0) step(1'b0, STAT, 32'h0, tag);
  endtask

  task automatic wait_tick(input int i, input string tag);
    while (m_cnt[i] != m_cur[i]) step(1'b0, STAT, 32'h0, tag);
  endtask

  function automatic logic [31:0] wword(input int i, input int v);
    return (32'(v) << (i*FW)) | (32'h1 << (i*FW+16));
  endfunction

  initial begin
    checks = 0; errors = 0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = CTRL; reg_wdata = '0;
    for (int i = 0; i < NUM; i++) begin
      m_cnt[i] = 0; m_cur[i] = RDIV; m_fld[i] = RDIV; m_busy[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(reg_rdata == exp_rd(CTRL), "R1", reg_rdata, exp_rd(CTRL));
    chk(clk_en == '0, "R1", 32'(clk_en), 32'h0);
    reg_addr = STAT; #1;
    chk(reg_rdata == 32'h0, "R1", reg_rdata, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    idle(12, "R1");

    // R2: plain periods for each divider
    step(1'b1, CTRL, wword(0, 5) | wword(1, 2) | wword(2, 7), "R2");
    wait_clear(2, "R2");
    idle(40, "R2");

    // R3: write without enable bits must not touch any field
    step(1'b1, CTRL, 32'h0000_ffff, "R3");
    step(1'b0, CTRL, 32'h0, "R3");
    idle(10, "R3");

    // R4: write to another address has no effect
    step(1'b1, OTHR, 32'hffff_ffff, "R4");
    step(1'b0, OTHR, 32'h0, "R4");
    idle(10, "R4");

    // R6: change ratio just after a boundary, old period must complete
    wait_tick(0, "R6");
    step(1'b0, STAT, 32'h0, "R6");
    step(1'b1, CTRL, wword(0, 9), "R6");
    wait_clear(0, "R6");
    idle(25, "R6");

    // R7: repeated writes while busy, only the last applies
    wait_tick(1, "R7");
    step(1'b0, STAT, 32'h0, "R7");
    step(1'b1, CTRL, wword(1, 12), "R7");
    step(1'b1, CTRL, wword(1, 1), "R7");
    wait_clear(1, "R7");
    idle(12, "R7");

    // R8: write lands in the boundary cycle of a busy divider
    step(1'b1, CTRL, wword(2, 4), "R8");
    wait_tick(2, "R8");
    step(1'b1, CTRL, wword(2, 6), "R8");
    step(1'b0, STAT, 32'h0, "R8");
    wait_clear(2, "R8");
    idle(20, "R8");

    // R9: extremes of the field
    step(1'b1, CTRL, wword(0, 0) | wword(1, 15), "R9");
    wait_clear(0, "R9");
    wait_clear(1, "R9");
    idle(40, "R9");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 2) step(1'b1, CTRL, $urandom, "R2");
      else if (r == 2) step(1'b1, OTHR, $urandom, "R4");
      else if (r < 9) step(1'b0, STAT, 32'h0, "R2");
      else if (r < 14) step(1'b0, CTRL, 32'h0, "R2");
      else step(1'b0, 12'($urandom), 32'h0, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule